// File: doc/BRIEF.md
# CMAC Subkey and Final-Block Formatter

This block sits beside a block cipher running in CBC mode and supplies the last step of a CMAC computation. The cipher first encrypts an all-zero block; that 128-bit result is presented on the subkey input with a one-cycle load strobe. The block doubles it in GF(2^128) to obtain the first subkey, doubles that again to obtain the second, and keeps both in registers.

When the message tail is ready, the caller presents the running CBC state, the final message bytes and their count, and raises a format request for one cycle. One cycle later the block presents the block that the cipher must encrypt last, with a one-cycle valid pulse. A full tail of 16 bytes is masked with the first subkey. A shorter tail gets a single 0x80 marker byte right after the data and is masked with the second subkey. For messages of one block or less, a chain-bypass input replaces the CBC state with zeros.

Top module: `cmac_tail_fmt`

## Requirements
- R1: After reset `blk_valid` is 0, `blk_out` is all zeros and both stored subkeys are zero.
- R2: On a cycle with `l_load` high, the first subkey becomes `l_in` shifted left by one bit over all 128 bits. If bit 127 of `l_in` was 1, bits [7:0] of the result are also XORed with 0x87.
- R3: In the same cycle, the second subkey becomes the first subkey, computed from that `l_in`, put through the same shift and conditional 0x87 rule.
- R4: The subkeys keep their values until the next `l_load`. A format request in the same cycle as a load uses the subkeys held before that load.
- R5: With a byte count of exactly 16, the formatted block is `chain_in` XOR `last_in` XOR the first subkey.
- R6: Message byte i occupies bits [127-8i : 120-8i]. With a count n from 1 to 15, bytes n..15 of `last_in` are ignored. Byte n of the combined value is XORed with 0x80, and the result is XORed with the second subkey.
- R7: A count of 0 is an empty message. All of `last_in` is ignored, 0x80 goes into byte 0, and the second subkey is used.
- R8: When `no_chain` is high, `chain_in` is treated as all zeros.
- R9: `blk_valid` is high in exactly the cycle after a cycle with `fmt_req` high. `blk_out` changes only on such a cycle and otherwise holds its last value.
- R10: A count from 17 to 31 is treated as a count of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_load | input | 1 | Strobe that captures `l_in` and derives both subkeys |
| l_in | input | 128 | Cipher output for the all-zero block |
| fmt_req | input | 1 | Request to format the final block |
| no_chain | input | 1 | Use zeros in place of the chaining state |
| chain_in | input | 128 | Running CBC state |
| last_in | input | 128 | Final message bytes, byte 0 in the top bits |
| last_cnt | input | 5 | Number of valid bytes in `last_in` |
| blk_out | output | 128 | Formatted final block |
| blk_valid | output | 1 | One-cycle pulse marking a new `blk_out` |

## Verification
The subkeys cannot be seen directly at the ports, so a wrong stored subkey only shows in the next formatted block. A count of 16 with zero chain and zero data exposes the first subkey. A count of 0 with the chain bypassed exposes the second subkey XORed with the marker byte. In both cases the error appears one cycle after the first request that follows the load. An error in the pad position or the byte mask shows up in the block formatted for the affected count, and an error in the valid register shows up in the very next cycle. The bench therefore follows every load with both probes. It also checks, at the ports, that tail bytes beyond the count and the bypassed chain state leave no trace in the output.

// File: rtl/cmac_fmt_pkg.sv
package cmac_fmt_pkg;

    localparam int DEF_BLK_BYTES = 16;
    localparam logic [7:0] DEF_RB = 8'h87;
    localparam logic [7:0] DEF_PAD = 8'h80;

    typedef enum logic {
        MASK_FULL = 1'b0,
        MASK_PART = 1'b1
    } mask_sel_e;

endpackage

// File: rtl/cmac_subkey_gen.sv
module cmac_subkey_gen
    import cmac_fmt_pkg::*;
#(
    parameter int         BLK_BYTES = DEF_BLK_BYTES,
    parameter logic [7:0] RB        = DEF_RB
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [BLK_BYTES*8-1:0] l_in,
    output logic [BLK_BYTES*8-1:0] k1,
    output logic [BLK_BYTES*8-1:0] k2
);
    localparam int W = BLK_BYTES * 8;

    typedef struct packed {
        logic [W-1:0] k1;
        logic [W-1:0] k2;
    } keys_t;

    keys_t keys_d, keys_q;

    // Doubling in GF(2^W): shift left, fold the carry back through RB.
    function automatic logic [W-1:0] gf_double(input logic [W-1:0] v);
        logic [W-1:0] r;
        r = {v[W-2:0], 1'b0};
        if (v[W-1]) begin
            r[7:0] = r[7:0] ^ RB;
        end
        return r;
    endfunction

    always_comb begin
        keys_d = keys_q;
        if (load) begin
            keys_d.k1 = gf_double(l_in);
            keys_d.k2 = gf_double(keys_d.k1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keys_q <= '0;
        end else begin
            keys_q <= keys_d;
        end
    end

    assign k1 = keys_q.k1;
    assign k2 = keys_q.k2;

    p_k1_from_l_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> keys_q.k1 == gf_double($past(l_in)));

    p_k2_from_k1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> keys_q.k2 == gf_double(keys_q.k1));

    p_keys_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(keys_q));

endmodule

// File: rtl/cmac_last_fmt.sv
module cmac_last_fmt
    import cmac_fmt_pkg::*;
#(
    parameter int         BLK_BYTES = DEF_BLK_BYTES,
    parameter int         CNT_W     = 5,
    parameter logic [7:0] PAD       = DEF_PAD
) (
    input  logic [BLK_BYTES*8-1:0] chain,
    input  logic                   no_chain,
    input  logic [BLK_BYTES*8-1:0] data,
    input  logic [CNT_W-1:0]       cnt,
    input  logic [BLK_BYTES*8-1:0] k1,
    input  logic [BLK_BYTES*8-1:0] k2,
    output logic [BLK_BYTES*8-1:0] blk
);
    localparam int W = BLK_BYTES * 8;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BLK_BYTES);

    logic [CNT_W-1:0]     cnt_eff;
    logic [BLK_BYTES-1:0] keep_vec;
    logic [BLK_BYTES-1:0] pad_vec;
    logic [W-1:0]         mixed;
    mask_sel_e            sel;

    // Counts beyond a block saturate to a full block.
    always_comb begin
        cnt_eff = (cnt > FULL_CNT) ? FULL_CNT : cnt;
        sel     = (cnt_eff == FULL_CNT) ? MASK_FULL : MASK_PART;
    end

    for (genvar b = 0; b < BLK_BYTES; b++) begin : g_byte
        localparam int HI = W - 1 - 8 * b;
        logic [7:0] c_b;
        logic [7:0] d_b;
        logic [7:0] p_b;
        always_comb begin
            keep_vec[b] = CNT_W'(b) < cnt_eff;
            pad_vec[b]  = CNT_W'(b) == cnt_eff;
            c_b = no_chain    ? 8'h00 : chain[HI -: 8];
            d_b = keep_vec[b] ? data[HI -: 8] : 8'h00;
            p_b = pad_vec[b]  ? PAD : 8'h00;
            mixed[HI -: 8] = c_b ^ d_b ^ p_b;
        end
    end

    always_comb begin
        blk = mixed ^ ((sel == MASK_FULL) ? k1 : k2);
    end

    // R6: at most one marker byte, none for a full block.
    always_comb begin
        a_pad_single_r6: assert ($onehot0(pad_vec));
        a_full_no_pad_r5: assert (sel != MASK_FULL || pad_vec == '0);
    end

endmodule

// File: rtl/cmac_tail_fmt.sv
module cmac_tail_fmt
    import cmac_fmt_pkg::*;
#(
    parameter int BLK_BYTES = DEF_BLK_BYTES,
    parameter int CNT_W     = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   l_load,
    input  logic [BLK_BYTES*8-1:0] l_in,
    input  logic                   fmt_req,
    input  logic                   no_chain,
    input  logic [BLK_BYTES*8-1:0] chain_in,
    input  logic [BLK_BYTES*8-1:0] last_in,
    input  logic [CNT_W-1:0]       last_cnt,
    output logic [BLK_BYTES*8-1:0] blk_out,
    output logic                   blk_valid
);
    localparam int W = BLK_BYTES * 8;

    typedef struct packed {
        logic         valid;
        logic [W-1:0] blk;
    } out_t;

    logic [W-1:0] k1_w, k2_w, fmt_w;
    out_t out_d, out_q;

    cmac_subkey_gen #(
        .BLK_BYTES(BLK_BYTES),
        .RB       (DEF_RB)
    ) u_keys (
        .clk  (clk),
        .rst_n(rst_n),
        .load (l_load),
        .l_in (l_in),
        .k1   (k1_w),
        .k2   (k2_w)
    );

    cmac_last_fmt #(
        .BLK_BYTES(BLK_BYTES),
        .CNT_W    (CNT_W),
        .PAD      (DEF_PAD)
    ) u_fmt (
        .chain   (chain_in),
        .no_chain(no_chain),
        .data    (last_in),
        .cnt     (last_cnt),
        .k1      (k1_w),
        .k2      (k2_w),
        .blk     (fmt_w)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = fmt_req;
        if (fmt_req) begin
            out_d.blk = fmt_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign blk_out   = out_q.blk;
    assign blk_valid = out_q.valid;

    p_valid_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_req |=> blk_valid);

    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_req |=> !blk_valid);

    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_req |=> $stable(blk_out));

endmodule

// File: tb/cmac_tail_fmt_test.sv
module cmac_tail_fmt_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         l_load = 1'b0;
    logic [127:0] l_in = '0;
    logic         fmt_req = 1'b0;
    logic         no_chain = 1'b0;
    logic [127:0] chain_in = '0;
    logic [127:0] last_in = '0;
    logic [4:0]   last_cnt = '0;
    logic [127:0] blk_out;
    logic         blk_valid;

    int n_run = 0;
    int n_fail = 0;
    logic [127:0] m_k1 = '0;
    logic [127:0] m_k2 = '0;
    logic [127:0] got;

    always #4 clk = ~clk;

    cmac_tail_fmt uut (
        .clk(clk), .rst_n(rst_n), .l_load(l_load), .l_in(l_in),
        .fmt_req(fmt_req), .no_chain(no_chain), .chain_in(chain_in),
        .last_in(last_in), .last_cnt(last_cnt),
        .blk_out(blk_out), .blk_valid(blk_valid)
    );

    function automatic logic [127:0] dbl(input logic [127:0] v);
        logic [127:0] r;
        r = {v[126:0], 1'b0};
        if (v[127]) r[7:0] = r[7:0] ^ 8'h87;
        return r;
    endfunction

    function automatic logic [127:0] expect_blk(input logic [127:0] c,
            input logic nc, input logic [127:0] d, input int n_in,
            input logic [127:0] ka, input logic [127:0] kb);
        logic [127:0] r;
        int n;
        n = (n_in > 16) ? 16 : n_in;
        r = nc ? '0 : c;
        for (int i = 0; i < 16; i++) begin
            if (i < n) r[127-8*i -: 8] = r[127-8*i -: 8] ^ d[127-8*i -: 8];
            if (i == n) r[127-8*i -: 8] = r[127-8*i -: 8] ^ 8'h80;
        end
        return r ^ ((n == 16) ? ka : kb);
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_l(input logic [127:0] v);
        @(negedge clk);
        l_in = v; l_load = 1'b1;
        @(negedge clk);
        l_load = 1'b0;
        m_k1 = dbl(v);
        m_k2 = dbl(m_k1);
    endtask

    task automatic do_fmt(input logic [127:0] c, input logic nc,
            input logic [127:0] d, input int n, output logic [127:0] res);
        @(negedge clk);
        chain_in = c; no_chain = nc; last_in = d; last_cnt = 5'(n);
        fmt_req = 1'b1;
        @(negedge clk);
        fmt_req = 1'b0;
        check("R9 valid", {127'd0, blk_valid}, 128'd1);
        res = blk_out;
    endtask

    task automatic fmt_check(input string req, input logic [127:0] c, input logic nc,
            input logic [127:0] d, input int n);
        logic [127:0] r;
        do_fmt(c, nc, d, n, r);
        check(req, r, expect_blk(c, nc, d, n, m_k1, m_k2));
    endtask

    task automatic t_reset();
        check("R1 valid", {127'd0, blk_valid}, 128'd0);
        check("R1 out", blk_out, 128'd0);
        // zero subkeys: full block of zeros formats to zero
        fmt_check("R1 subkeys", '0, 1'b0, '0, 16);
    endtask

    task automatic t_known_vector();
        logic [127:0] r;
        load_l(128'h7df76b0c1ab899b33e42f047b91b546f);
        do_fmt('0, 1'b1, '0, 16, r);
        check("R2 k1 no fold", r, 128'hfbeed618357133667c85e08f7236a8de);
        do_fmt('0, 1'b1, '0, 0, r);
        check("R3 k2 fold", r, 128'hf7ddac306ae266ccf90bc11ee46d513b ^ {8'h80, 120'd0});
    endtask

    task automatic t_fold();
        logic [127:0] r;
        load_l(128'hC000_0000_0000_0000_0000_0000_0000_0001);
        do_fmt('0, 1'b1, '0, 16, r);
        check("R2 fold", r, 128'h8000_0000_0000_0000_0000_0000_0000_0085);
        do_fmt('0, 1'b1, '0, 0, r);
        check("R3 fold", r, 128'h0000_0000_0000_0000_0000_0000_0000_018D ^ {8'h80, 120'd0});
    endtask

    task automatic t_full();
        fmt_check("R5 full", 128'h0123456789abcdef_fedcba9876543210, 1'b0,
                  128'h5555aaaa3333cccc_0f0f0f0ff0f0f0f0, 16);
    endtask

    task automatic t_partial();
        logic [127:0] c = 128'h1111111122222222_3333333344444444;
        logic [127:0] d = 128'hdeadbeefcafef00d_0badc0de12345678;
        fmt_check("R6 cnt5", c, 1'b0, d, 5);
        fmt_check("R6 cnt1", c, 1'b0, d, 1);
        fmt_check("R6 cnt15", c, 1'b0, d, 15);
        // ignored bytes: changing data beyond count leaves output unchanged
        fmt_check("R6 ignored", c, 1'b0, {d[127:88], 88'hffffffffffffffffffffff}, 5);
    endtask

    task automatic t_empty();
        fmt_check("R7 empty", 128'h00ff00ff00ff00ff_00ff00ff00ff00ff, 1'b0, {128{1'b1}}, 0);
    endtask

    task automatic t_bypass();
        fmt_check("R8 bypass", 128'h9999999999999999_9999999999999999, 1'b1,
                  128'h0102030405060708_090a0b0c0d0e0f10, 9);
    endtask

    task automatic t_sat();
        logic [127:0] d = 128'h0f1e2d3c4b5a6978_8796a5b4c3d2e1f0;
        fmt_check("R10 cnt20", 128'h5a5a, 1'b0, d, 20);
        fmt_check("R10 cnt31", 128'h5a5a, 1'b0, d, 31);
    endtask

    task automatic t_hold();
        logic [127:0] r;
        do_fmt(128'h77, 1'b0, 128'h33, 3, r);
        chain_in = '1; last_in = '1; last_cnt = 5'd7;
        @(negedge clk);
        check("R9 pulse", {127'd0, blk_valid}, 128'd0);
        check("R9 hold", blk_out, r);
    endtask

    task automatic t_same_cycle();
        logic [127:0] old_k1 = m_k1;
        @(negedge clk);
        l_in = 128'h0000_1111_2222_3333_4444_5555_6666_7777; l_load = 1'b1;
        chain_in = '0; no_chain = 1'b1; last_in = '0; last_cnt = 5'd16; fmt_req = 1'b1;
        @(negedge clk);
        l_load = 1'b0; fmt_req = 1'b0;
        check("R4 old keys", blk_out, old_k1);
        m_k1 = dbl(128'h0000_1111_2222_3333_4444_5555_6666_7777);
        m_k2 = dbl(m_k1);
        repeat (3) @(negedge clk);
        fmt_check("R4 new keys held", '0, 1'b1, '0, 16);
        fmt_check("R4 new k2", '0, 1'b1, '0, 0);
    endtask

    initial begin
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known_vector();
        t_fold();
        t_full();
        t_partial();
        t_empty();
        t_bypass();
        t_sat();
        t_hold();
        t_same_cycle();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule